// File: doc/BRIEF.md
# Multi-Mode Conversion Period and Data-Ready Timer

This block paces a multi-mode sampling converter. It runs on the converter master clock and counts master-clock cycles to mark the end of every conversion period. The period length comes from a 2-bit operating-mode select and a clock-divide select. A single-cycle period strobe is issued at each period boundary, and the data-ready signalling is derived from that strobe for the chosen output protocol.

The mode and divide pins are sampled continuously through a two-flop synchronizer. A new configuration needs no reset. When the configuration changes, the period count restarts at zero. Valid-data indication is then withheld for a settling interval of `SETTLE_PERIODS` whole conversion periods. In SPI protocol, the active-low data-ready line pulses low for one cycle at each valid boundary and stays high during the hold-off. In frame-sync protocol, the data-ready line is unused and held high. A data-line qualifier stays low through the hold-off and goes high once settled data exist.

Top module: `conv_timer`

## Requirements
- R1: While reset is asserted, `drdy_n` is 1 and `period_strobe` and `frame_ok` are 0. Reset selects mode 00 with divide 0 and arms the settling hold-off.
- R2: Mode code 00 (high-speed) gives a period of 256 master-clock cycles. Mode code 01 (high-resolution) gives 512.
- R3: Mode code 10 (low-power) gives a period of 512 cycles with `div_sel`=1 and 256 cycles with `div_sel`=0.
- R4: Mode code 11 (low-speed) gives a period of 2560 cycles with `div_sel`=1 and 512 cycles with `div_sel`=0.
- R5: `period_strobe` is high for exactly one cycle per period, and consecutive strobes are exactly one period apart.
- R6: A configuration change restarts the count. The change is either a new mode code, or a new divide value while the mode code has bit 1 set. The first strobe after the change comes at the (period+3)-th falling clock edge after the pins change, provided they change just after a strobe. Two cycles of that delay are the synchronizer and one is change detection.
- R7: After reset and after every configuration change, the first `SETTLE_PERIODS` strobes (default 2) are not flagged as valid data. The next strobe is flagged.
- R8: With `proto_fs`=0 (SPI), `drdy_n` is low exactly in the strobe cycle of a valid period and high in every other cycle.
- R9: With `proto_fs`=1 (frame-sync), `drdy_n` stays high. `frame_ok` is 0 during the hold-off and 1 once it ends, until the next change. With `proto_fs`=0, `frame_ok` stays 0.
- R10: In modes 00 and 01, toggling `div_sel` has no effect. The period continues unbroken and no hold-off starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Operating mode code, asynchronous pins |
| div_sel | input | 1 | Clock-divide select, asynchronous pin |
| proto_fs | input | 1 | Protocol select: 0 SPI, 1 frame-sync (static strap) |
| drdy_n | output | 1 | Active-low data-ready pulse, SPI protocol |
| frame_ok | output | 1 | Data-line qualifier, frame-sync protocol |
| period_strobe | output | 1 | One-cycle end-of-conversion strobe |

## Verification
The checker treats `proto_fs` as a strap that is constant outside reset. It relates the change-detect wire to the counter restart and the hold-off, one and two cycles later. Mode and divide pins may change at any time, since they pass through the synchronizer. The bench changes them only on a falling edge just after a strobe, so the exact restart latency can be predicted. It alters the protocol strap only while reset is asserted.

// File: rtl/conv_timer_pkg.sv
package conv_timer_pkg;

  typedef enum logic [1:0] {
    MD_FAST = 2'b00,
    MD_FINE = 2'b01,
    MD_LEAN = 2'b10,
    MD_SLOW = 2'b11
  } conv_mode_e;

  localparam int unsigned RATIO_SHORT = 256;
  localparam int unsigned RATIO_MID   = 512;
  localparam int unsigned RATIO_LONG  = 2560;
  localparam int unsigned CNT_W       = $clog2(RATIO_LONG);
  localparam int unsigned CFG_W       = 3;

  // master-clock cycles per output word
  function automatic logic [CNT_W-1:0] period_of(conv_mode_e m, logic div);
    case (m)
      MD_FAST: period_of = CNT_W'(RATIO_SHORT);
      MD_FINE: period_of = CNT_W'(RATIO_MID);
      MD_LEAN: period_of = div ? CNT_W'(RATIO_MID)  : CNT_W'(RATIO_SHORT);
      default: period_of = div ? CNT_W'(RATIO_LONG) : CNT_W'(RATIO_MID);
    endcase
  endfunction

  // only the two slower modes look at the divide pin
  function automatic logic div_matters(conv_mode_e m);
    div_matters = m[1];
  endfunction

endpackage

// File: rtl/conv_cfg_sync.sv
module conv_cfg_sync
  import conv_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_raw,
  input  logic             div_raw,
  output conv_mode_e       mode_cur,
  output logic             div_cur,
  output logic             cfg_change
);
  logic [CFG_W-1:0] stage1_q, stage2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= {mode_raw, div_raw};
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  conv_mode_e mode_prev;
  assign mode_cur  = conv_mode_e'(stage2_q[2:1]);
  assign div_cur   = stage2_q[0];
  assign mode_prev = conv_mode_e'(prev_q[2:1]);

  assign cfg_change = (mode_cur != mode_prev) ||
                      (div_matters(mode_cur) && (div_cur != prev_q[0]));
endmodule

// File: rtl/conv_period_ctr.sv
module conv_period_ctr
  import conv_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] ratio,
  output logic [CNT_W-1:0] cnt,
  output logic             eop
);
  assign eop = (cnt == ratio - CNT_W'(1)) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (eop)     cnt <= '0;
    else              cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/conv_settle.sv
module conv_settle #(
  parameter int unsigned SETTLE_PERIODS = 2,
  localparam int unsigned HOLD_W = $clog2(SETTLE_PERIODS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic eop,
  input  logic proto_fs,
  output logic settled,
  output logic drdy_n,
  output logic frame_ok,
  output logic period_strobe
);
  localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(SETTLE_PERIODS);

  logic [HOLD_W-1:0] hold_q;
  logic              valid_eop;

  assign settled   = (hold_q == '0);
  assign valid_eop = eop && settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold_q <= HOLD_INIT;
    else if (restart)          hold_q <= HOLD_INIT;
    else if (eop && !settled)  hold_q <= hold_q - HOLD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drdy_n        <= 1'b1;
      frame_ok      <= 1'b0;
      period_strobe <= 1'b0;
    end else begin
      drdy_n        <= !(valid_eop && !proto_fs);
      frame_ok      <= proto_fs && settled && !restart;
      period_strobe <= eop;
    end
  end
endmodule

// File: rtl/conv_timer.sv
module conv_timer
  import conv_timer_pkg::*;
#(
  parameter int unsigned SETTLE_PERIODS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       div_sel,
  input  logic       proto_fs,
  output logic       drdy_n,
  output logic       frame_ok,
  output logic       period_strobe
);
  conv_mode_e       mode_cur;
  logic             div_cur;
  logic             cfg_change;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] period_cnt;
  logic             eop;
  logic             settled;

  conv_cfg_sync u_sync (
    .clk(clk), .rst_n(rst_n), .mode_raw(mode_sel), .div_raw(div_sel),
    .mode_cur(mode_cur), .div_cur(div_cur), .cfg_change(cfg_change)
  );

  assign ratio = period_of(mode_cur, div_cur);

  conv_period_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .restart(cfg_change), .ratio(ratio),
    .cnt(period_cnt), .eop(eop)
  );

  conv_settle #(.SETTLE_PERIODS(SETTLE_PERIODS)) u_settle (
    .clk(clk), .rst_n(rst_n), .restart(cfg_change), .eop(eop),
    .proto_fs(proto_fs), .settled(settled), .drdy_n(drdy_n),
    .frame_ok(frame_ok), .period_strobe(period_strobe)
  );
endmodule

// File: rtl/conv_timer_chk.sv
module conv_timer_chk
  import conv_timer_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             proto_fs,
  input logic             drdy_n,
  input logic             frame_ok,
  input logic             period_strobe,
  input logic             cfg_change,
  input logic             eop,
  input logic [CNT_W-1:0] period_cnt,
  input logic [CNT_W-1:0] ratio
);
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    period_strobe |=> !period_strobe);

  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    period_cnt < ratio);

  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> (period_cnt == '0));

  a_r7_holdoff_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> ##1 !frame_ok);

  a_r8_drdy_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !drdy_n |-> period_strobe);

  a_r8_drdy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !drdy_n |=> drdy_n);

  a_r9_fs_drdy_idle: assert property (@(posedge clk) disable iff (!rst_n)
    proto_fs |-> drdy_n);

  a_r9_spi_frame_low: assert property (@(posedge clk) disable iff (!rst_n)
    !proto_fs |=> !frame_ok);

  a_r5_strobe_follows_eop: assert property (@(posedge clk) disable iff (!rst_n)
    eop |=> period_strobe);
endmodule

bind conv_timer conv_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .proto_fs(proto_fs), .drdy_n(drdy_n),
  .frame_ok(frame_ok), .period_strobe(period_strobe),
  .cfg_change(cfg_change), .eop(eop), .period_cnt(period_cnt), .ratio(ratio)
);

// File: tb/conv_timer_tb_top.sv
module conv_timer_tb_top;
  localparam int SETTLE = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic [1:0] mode_sel;
  logic       div_sel;
  logic       proto_fs;
  wire        drdy_n, frame_ok, period_strobe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  conv_timer #(.SETTLE_PERIODS(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .div_sel(div_sel),
    .proto_fs(proto_fs), .drdy_n(drdy_n), .frame_ok(frame_ok),
    .period_strobe(period_strobe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // counts falling edges until one shows the strobe; counts stray drdy lows
  task automatic next_strobe(output int gap, output int lows);
    gap = 0; lows = 0;
    do begin
      @(negedge clk);
      gap++;
      if (!period_strobe && !drdy_n) lows++;
    end while (!period_strobe && gap < 4000);
  endtask

  task automatic do_reset(input bit fs);
    @(negedge clk);
    rst_n = 1'b0; mode_sel = 2'b00; div_sel = 1'b0; proto_fs = fs;
    repeat (3) @(negedge clk);
    chk(drdy_n == 1'b1,        "R1", "drdy_n in reset", drdy_n, 1);
    chk(period_strobe == 1'b0, "R1", "strobe in reset", period_strobe, 0);
    chk(frame_ok == 1'b0,      "R1", "frame_ok in reset", frame_ok, 0);
    rst_n = 1'b1;
  endtask

  // hold-off strobes, then two settled strobes
  task automatic run_settled(input int ratio, input bit fs, input string req,
                             input int first_gap);
    int gap, lows;
    for (int k = 1; k <= SETTLE + 2; k++) begin
      next_strobe(gap, lows);
      chk(gap == ((k == 1) ? first_gap : ratio), req, "strobe spacing", gap,
          (k == 1) ? first_gap : ratio);
      chk(lows == 0, "R8", "drdy_n low off strobe", lows, 0);
      if (k <= SETTLE) begin
        chk(drdy_n == 1'b1,   "R7", "drdy_n during hold-off", drdy_n, 1);
        chk(frame_ok == 1'b0, "R7", "frame_ok during hold-off", frame_ok, 0);
      end else if (!fs) begin
        chk(drdy_n == 1'b0,   "R8", "drdy_n at valid strobe", drdy_n, 0);
        chk(frame_ok == 1'b0, "R9", "frame_ok in SPI", frame_ok, 0);
      end else begin
        chk(drdy_n == 1'b1,   "R9", "drdy_n in frame-sync", drdy_n, 1);
        chk(frame_ok == 1'b1, "R9", "frame_ok settled", frame_ok, 1);
      end
    end
  endtask

  // called just after a strobe: counter is far from its next boundary
  task automatic change_cfg(input logic [1:0] m, input logic d, input int ratio,
                            input bit fs, input string req);
    mode_sel = m; div_sel = d;
    run_settled(ratio, fs, req, ratio + 3); // R6: two sync flops + detect
  endtask

  task automatic div_ignored(input int ratio);
    int gap, lows;
    div_sel = ~div_sel;
    next_strobe(gap, lows);
    chk(gap == ratio,   "R10", "period after div toggle", gap, ratio);
    chk(drdy_n == 1'b0, "R10", "no hold-off after div toggle", drdy_n, 0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'b00; div_sel = 1'b0; proto_fs = 1'b0;
    // SPI protocol
    do_reset(1'b0);
    run_settled(256, 1'b0, "R2", 256);
    div_ignored(256);
    change_cfg(2'b01, div_sel, 512, 1'b0, "R2");
    div_ignored(512);
    change_cfg(2'b10, 1'b1, 512, 1'b0, "R3");
    change_cfg(2'b10, 1'b0, 256, 1'b0, "R3");
    change_cfg(2'b11, 1'b0, 512, 1'b0, "R4");
    change_cfg(2'b11, 1'b1, 2560, 1'b0, "R4");
    change_cfg(2'b00, 1'b1, 256, 1'b0, "R6");
    // frame-sync protocol
    do_reset(1'b1);
    run_settled(256, 1'b1, "R9", 256);
    change_cfg(2'b11, 1'b1, 2560, 1'b1, "R9");
    change_cfg(2'b10, 1'b0, 256, 1'b1, "R5");
    done = 1'b1;
    finish_run();
  end
endmodule